// File: doc/BRIEF.md
# Configuration Port Register Access Sequencer

This block lets a host reach one register of a 32-bit internal configuration port per request. The host places a 5-bit register address and, for writes, a 32-bit data word on its inputs and raises either a write strobe or a read strobe. The block then plays a fixed stream of words into the port, one word per clock, while driving an active-low select and a direction line (low means the port is being written, high means it is being read).

Every stream opens with a synchronisation word and two no-op words and closes by writing the desynchronise code into the command register, followed by two no-op words. Between the opening and the closing, a write emits a type-1 write header and the data word. A read emits a type-1 read header, releases the port for one turnaround cycle and then holds a four-cycle read window. The last word sampled in that window is returned to the host. A single-cycle done flag marks the last word of the stream. Writing 0x0000000F to the command register (address 4) asks the device to reload its configuration.

Top module: `cfgp_seq`

## Requirements
- R1: After reset, and whenever no request is in progress, port_cs_n and port_dir are 1, port_din is the no-op word 0x20000000, and done is 0.
- R2: A strobe is sampled only at a clock edge where the block is idle. The sync word 0xAA995566 appears on port_din in the cycle after that edge, and two no-op words follow it. All three words have port_cs_n=0 and port_dir=0.
- R3: The fourth word is a type-1 header. It has bits[31:29]=001 and bits[28:27] as the opcode (01 read, 10 write). Bits[17:13] hold the register address, bits[10:0] hold the word count 1, and every other bit is 0. For example, a write to address 4 gives 0x30008001 and a read of address 22 gives 0x2802C001.
- R4: A write emits exactly 11 words with port_cs_n=0 and port_dir=0: sync, no-op, no-op, header, data, no-op, no-op, 0x30008001, 0x0000000D, no-op, no-op.
- R5: A read emits sync, no-op, no-op, header, no-op and no-op, all with port_cs_n=0 and port_dir=0.
- R6: After the words of R5, a read spends one turnaround cycle with port_cs_n=1 and port_dir=1. It then spends four cycles with port_cs_n=0, port_dir=1 and a no-op on port_din.
- R7: A read then returns port_dir to 0 and emits 0x30008001, 0x0000000D, no-op and no-op, which makes 15 cycles in all.
- R8: A read captures port_dout on the fourth cycle of the read window. From then on rd_data shows that value, including in the done cycle, and rd_data changes at no other time.
- R9: done is 1 for exactly one cycle, the cycle of the last word of the stream.
- R10: Strobes raised while a stream is in progress have no effect on the stream. When both strobes are sampled together, the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Write strobe, held until done |
| rd_req | input | 1 | Read strobe, held until done |
| req_addr | input | 5 | Target register address |
| wr_data | input | 32 | Data word for a write |
| done | output | 1 | One-cycle completion flag |
| rd_data | output | 32 | Word captured by the last read |
| port_cs_n | output | 1 | Port select, active low |
| port_dir | output | 1 | Port direction, 1 = read |
| port_din | output | 32 | Word driven into the port |
| port_dout | input | 32 | Word returned by the port |

## Verification
The assertions assume that the host drops its strobe in the same cycle in which it sees done, before the next edge. If the strobe were still high at that edge, the block would be idle there and would start a new stream. The bench meets this assumption by driving every input half a cycle away from the active edge and by clearing both strobes in the cycle that shows done. The bench raises the opposite strobe only while a stream is running. It drives port_dout from a counter that changes every cycle, so a capture taken in the wrong cycle produces a value that differs from the expected one.

// File: rtl/cfgp_pkg.sv
// Shared constants, opcode type and header builder for the configuration
// port sequencer. Assumes a 32-bit port word and a 5-bit register address.
package cfgp_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 5;
    localparam int STEP_W = 4;

    localparam logic [WORD_W-1:0] SYNC_WORD   = 32'hAA995566;
    localparam logic [WORD_W-1:0] NOP_WORD    = 32'h20000000;
    localparam logic [WORD_W-1:0] DESYNC_CODE = 32'h0000000D;
    localparam logic [ADDR_W-1:0] CMD_REG     = 5'd4;

    // Step indices of each stream (the sequence order is behaviour)
    localparam logic [STEP_W-1:0] ST_SYNC     = 4'd0;
    localparam logic [STEP_W-1:0] ST_HDR      = 4'd3;
    localparam logic [STEP_W-1:0] ST_WDATA    = 4'd4;
    localparam logic [STEP_W-1:0] WR_DS_HDR   = 4'd7;
    localparam logic [STEP_W-1:0] WR_LAST     = 4'd10;
    localparam logic [STEP_W-1:0] RD_TURN     = 4'd6;
    localparam logic [STEP_W-1:0] RD_WIN_LO   = 4'd7;
    localparam logic [STEP_W-1:0] RD_CAP      = 4'd10;
    localparam logic [STEP_W-1:0] RD_DS_HDR   = 4'd11;
    localparam logic [STEP_W-1:0] RD_LAST     = 4'd14;

    typedef enum logic [1:0] {
        OP_RD = 2'b01,
        OP_WR = 2'b10
    } op_e;

    // Builds a type-1 single-word header for the given opcode and address.
    function automatic logic [WORD_W-1:0] type1_hdr(op_e op, logic [ADDR_W-1:0] a);
        return {3'b001, op, 9'd0, a, 2'b00, 11'd1};
    endfunction
endpackage

// File: rtl/cfgp_hdr.sv
// Header generator: forms the request header for the latched address and the
// fixed command-register write header used by the closing desync.
// Assumes inputs are stable for the whole stream (latched by the controller).
module cfgp_hdr
    import cfgp_pkg::*;
(
    input  logic              is_rd,
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] req_hdr,
    output logic [WORD_W-1:0] ds_hdr
);
    // Select opcode and build both headers
    always_comb begin
        req_hdr = type1_hdr(is_rd ? OP_RD : OP_WR, addr);
        ds_hdr  = type1_hdr(OP_WR, CMD_REG);
    end
endmodule

// File: rtl/cfgp_ctrl.sv
// Request controller: accepts a strobe only when idle (write wins a tie),
// latches address and data, and walks the step counter to the stream end.
// Assumes the host drops its strobe in the cycle that shows done.
module cfgp_ctrl
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              busy,
    output logic              is_rd,
    output logic [STEP_W-1:0] step,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [WORD_W-1:0] lat_data,
    output logic              last
);
    // Final step of the running stream
    always_comb begin
        last = busy && (step == (is_rd ? RD_LAST : WR_LAST));
    end

    // Accept, latch and advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            is_rd    <= 1'b0;
            step     <= '0;
            lat_addr <= '0;
            lat_data <= '0;
        end else if (!busy) begin
            if (wr_req || rd_req) begin
                busy     <= 1'b1;
                is_rd    <= !wr_req;
                step     <= ST_SYNC;
                lat_addr <= req_addr;
                lat_data <= wr_data;
            end
        end else if (last) begin
            busy <= 1'b0;
            step <= '0;
        end else begin
            step <= step + 1'b1;
        end
    end
endmodule

// File: rtl/cfgp_emit.sv
// Word emitter: maps the current step to the port select, direction and word
// for the write or read stream. Purely combinational; idle drives no-op.
module cfgp_emit
    import cfgp_pkg::*;
(
    input  logic              busy,
    input  logic              is_rd,
    input  logic [STEP_W-1:0] step,
    input  logic [WORD_W-1:0] req_hdr,
    input  logic [WORD_W-1:0] ds_hdr,
    input  logic [WORD_W-1:0] wdata,
    output logic              cs_n,
    output logic              dir,
    output logic [WORD_W-1:0] din
);
    // Decode step into the port triple
    always_comb begin
        cs_n = 1'b1;
        dir  = 1'b1;
        din  = NOP_WORD;
        if (busy) begin
            cs_n = 1'b0;
            dir  = 1'b0;
            if (!is_rd) begin
                case (step)
                    ST_SYNC:   din = SYNC_WORD;
                    ST_HDR:    din = req_hdr;
                    ST_WDATA:  din = wdata;
                    WR_DS_HDR: din = ds_hdr;
                    WR_DS_HDR + 4'd1: din = DESYNC_CODE;
                    default:   din = NOP_WORD;
                endcase
            end else begin
                case (step)
                    ST_SYNC:   din = SYNC_WORD;
                    ST_HDR:    din = req_hdr;
                    RD_TURN: begin
                        cs_n = 1'b1;
                        dir  = 1'b1;
                    end
                    RD_DS_HDR: din = ds_hdr;
                    RD_DS_HDR + 4'd1: din = DESYNC_CODE;
                    default:   din = NOP_WORD;
                endcase
                if (step >= RD_WIN_LO && step <= RD_CAP) begin
                    dir = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cfgp_seq.sv
// Top of the configuration port sequencer: controller, header generator and
// word emitter, plus the read capture register. Single clock domain.
module cfgp_seq
    import cfgp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [4:0]        req_addr,
    input  logic [31:0]       wr_data,
    output logic              done,
    output logic [31:0]       rd_data,
    output logic              port_cs_n,
    output logic              port_dir,
    output logic [31:0]       port_din,
    input  logic [31:0]       port_dout
);
    logic              busy;
    logic              is_rd;
    logic              last;
    logic [STEP_W-1:0] step;
    logic [ADDR_W-1:0] lat_addr;
    logic [WORD_W-1:0] lat_data;
    logic [WORD_W-1:0] req_hdr;
    logic [WORD_W-1:0] ds_hdr;
    logic [WORD_W-1:0] rd_q;

    cfgp_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
        .req_addr(req_addr), .wr_data(wr_data), .busy(busy), .is_rd(is_rd),
        .step(step), .lat_addr(lat_addr), .lat_data(lat_data), .last(last)
    );

    cfgp_hdr u_hdr (
        .is_rd(is_rd), .addr(lat_addr), .req_hdr(req_hdr), .ds_hdr(ds_hdr)
    );

    cfgp_emit u_emit (
        .busy(busy), .is_rd(is_rd), .step(step), .req_hdr(req_hdr),
        .ds_hdr(ds_hdr), .wdata(lat_data), .cs_n(port_cs_n), .dir(port_dir),
        .din(port_din)
    );

    // Capture the port word on the last read-window cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (busy && is_rd && step == RD_CAP) begin
            rd_q <= port_dout;
        end
    end

    assign rd_data = rd_q;
    assign done    = last;
endmodule

// File: rtl/cfgp_seq_chk.sv
// Property checker for cfgp_seq, attached by bind. Observes ports and the
// controller's busy state only.
module cfgp_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        port_cs_n,
    input logic        port_dir,
    input logic [31:0] port_din,
    input logic [31:0] rd_data
);
    // R1
    idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (port_cs_n && port_dir && port_din == 32'h20000000 && !done));

    // R2
    sync_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !port_cs_n && port_din == 32'hAA995566) |-> $past(!busy));

    // R6
    deselect_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_cs_n |-> port_dir);

    // R7
    done_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!port_cs_n && !port_dir && port_din == 32'h20000000));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(rd_data));
endmodule

bind cfgp_seq cfgp_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .port_cs_n(port_cs_n), .port_dir(port_dir), .port_din(port_din),
    .rd_data(rd_data)
);

// File: tb/cfgp_seq_bench.sv
// Scoreboard bench: the driver queues the expected port triple of each
// stream, the monitor pops and compares them from the first sync word on.
module cfgp_seq_bench;
    localparam logic [31:0] SYNC = 32'hAA995566;
    localparam logic [31:0] NOP  = 32'h20000000;

    typedef struct packed {
        logic [3:0]  req;
        logic        dn;
        logic        cap;
        logic        cs;
        logic        dir;
        logic [31:0] w;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req = 1'b0;
    logic        rd_req = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [31:0] wr_data = '0;
    logic        done;
    logic [31:0] rd_data;
    logic        port_cs_n;
    logic        port_dir;
    logic [31:0] port_din;
    logic [31:0] port_dout;
    logic [31:0] cyc = '0;

    item_t       q[$];
    logic        mon_on = 1'b0;
    logic [31:0] cap_val = '0;
    int          tests = 0;
    int          fails = 0;
    logic        finished = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign port_dout = 32'hC0DE0000 ^ cyc;

    cfgp_seq u_cfgp_seq (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
        .req_addr(req_addr), .wr_data(wr_data), .done(done), .rd_data(rd_data),
        .port_cs_n(port_cs_n), .port_dir(port_dir), .port_din(port_din),
        .port_dout(port_dout)
    );

    function automatic logic [31:0] hdr(bit rd, logic [4:0] a);
        return {3'b001, (rd ? 2'b01 : 2'b10), 9'd0, a, 2'b00, 11'd1};
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(int r, bit cs, bit dir, logic [31:0] w, bit dn, bit cap);
        item_t it;
        it.req = 4'(r); it.dn = dn; it.cap = cap; it.cs = cs; it.dir = dir; it.w = w;
        q.push_back(it);
    endtask

    // Expected stream: R2 prologue, R3 header, R4 write / R5-R7 read tail
    task automatic build(bit rd, logic [4:0] a, logic [31:0] d);
        push(2, 0, 0, SYNC, 0, 0);
        push(2, 0, 0, NOP, 0, 0);
        push(2, 0, 0, NOP, 0, 0);
        push(3, 0, 0, hdr(rd, a), 0, 0);
        if (!rd) begin
            push(4, 0, 0, d, 0, 0);
            push(4, 0, 0, NOP, 0, 0);
            push(4, 0, 0, NOP, 0, 0);
        end else begin
            push(5, 0, 0, NOP, 0, 0);
            push(5, 0, 0, NOP, 0, 0);
            push(6, 1, 1, NOP, 0, 0);
            for (int i = 0; i < 4; i++) push(6, 0, 1, NOP, 0, i == 3);
        end
        push(7, 0, 0, 32'h30008001, 0, 0);
        push(7, 0, 0, 32'h0000000D, 0, 0);
        push(7, 0, 0, NOP, 0, 0);
        push(9, 0, 0, NOP, 1, 0);
    endtask

    // Monitor: compare every cycle from the first sync word
    always @(negedge clk) begin
        if (rst_n && q.size() > 0 && (mon_on || (port_din == SYNC && !port_cs_n))) begin
            item_t it;
            mon_on = 1'b1;
            it = q.pop_front();
            tests++;
            if ({done, port_cs_n, port_dir, port_din} !== {it.dn, it.cs, it.dir, it.w}) begin
                fails++;
                $display("FAIL R%0d stream actual=%b/%b/%b/%h expected=%b/%b/%b/%h",
                         it.req, done, port_cs_n, port_dir, port_din,
                         it.dn, it.cs, it.dir, it.w);
            end
            if (it.cap) cap_val = port_dout;
            if (q.size() == 0) mon_on = 1'b0;
        end
    end

    // Driver: one request; poke raises the other strobe mid-stream (R10)
    task automatic do_req(bit rd, logic [4:0] a, logic [31:0] d, bit poke);
        int n;
        logic [31:0] rd_before;
        build(rd, a, d);
        @(negedge clk);
        req_addr = a;
        wr_data  = d;
        if (rd) rd_req = 1'b1; else wr_req = 1'b1;
        @(negedge clk);
        // R2: sync appears the cycle after the strobe is sampled
        chk("R2 sync timing", {32'd0, port_din}, {32'd0, SYNC});
        n = 0;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
            if (poke && n == 3) begin
                if (rd) wr_req = 1'b1; else rd_req = 1'b1;
            end
            if (poke && n == 6) begin
                if (rd) wr_req = 1'b0; else rd_req = 1'b0;
            end
        end
        wr_req = 1'b0;
        rd_req = 1'b0;
        // R8: capture is visible when done pulses
        if (rd) chk("R8 read data", {32'd0, rd_data}, {32'd0, cap_val});
        rd_before = rd_data;
        @(negedge clk);
        // R9: done lasts one cycle; R1: back to idle; R10: no restart
        chk("R9 done single", {63'd0, done}, 64'd0);
        chk("R1 idle triple", {30'd0, port_cs_n, port_dir, port_din}, {30'd0, 1'b1, 1'b1, NOP});
        chk("R4 stream consumed", 64'(q.size()), 64'd0);
        repeat (3) @(negedge clk);
        chk("R10 no restart", {30'd0, port_cs_n, port_dir, port_din}, {30'd0, 1'b1, 1'b1, NOP});
        chk("R8 rd hold", {32'd0, rd_data}, {32'd0, rd_before});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset", {29'd0, done, port_cs_n, port_dir, port_din}, {29'd0, 1'b0, 1'b1, 1'b1, NOP});
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {29'd0, done, port_cs_n, port_dir, port_din}, {29'd0, 1'b0, 1'b1, 1'b1, NOP});
        do_req(0, 5'd4, 32'h0000000F, 0);   // R4 reload command
        do_req(1, 5'd22, 32'h0, 0);         // R5 R6 R7 boot-status read
        do_req(0, 5'd31, 32'hA5A55A5A, 1);  // R3 R10 write with poke
        do_req(1, 5'd0, 32'h0, 1);          // R10 read with poke
        do_req(0, 5'd13, 32'h00000000, 0);  // R4 zero data
        // R10: both strobes together perform a write
        do_req(0, 5'd9, 32'h12345678, 0);
        build(0, 5'd2, 32'hDEADBEEF);
        @(negedge clk);
        req_addr = 5'd2; wr_data = 32'hDEADBEEF; wr_req = 1'b1; rd_req = 1'b1;
        while (!done) @(negedge clk);
        wr_req = 1'b0; rd_req = 1'b0;
        @(negedge clk);
        chk("R10 tie write", 64'(q.size()), 64'd0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL R9 watchdog actual=no-end expected=end");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule